// File: doc/BRIEF.md
# PLL-Aware Reset Sequencer

This block turns a raw external reset request and a raw PLL lock flag into clean, clock-aligned resets for a design that runs from a PLL. It works in two clock domains. In the reference-clock domain it drives the PLL's reset. It holds that reset for a programmable number of reference cycles after the external request goes away. In the PLL-clock domain it holds a system reset until two conditions are met: the PLL reset, as seen in that domain, has been released, and lock has been continuously present for a programmable number of PLL cycles. A copy of the system reset, registered once more, is then fanned out to each downstream module.

Both raw inputs are asynchronous, so each one passes through a two-flop synchronizer before any logic uses it. The PLL reset also crosses into the PLL-clock domain through a two-flop synchronizer there. Hold durations come from down/up counters, so holds of thousands of cycles cost only a few flops. All outputs are active-high and synchronous to their own clock. The block has no data path, so there is no valid/ready interface and no back-pressure: every pin is a plain level. Flops power up in the reset-asserted state, so the outputs are defined from the first clock.

Top module: `reset_sequencer`

## Requirements
- R1: While the external reset request is held high, `pll_rst`, `sys_rst` and every bit of `mod_rst` are high.
- R2: A rising external reset request, driven between reference edges, sets `pll_rst` high on the third following `ref_clk` rising edge. This follows two synchronizer flops and one output register, and it holds whatever the lock state is.
- R3: After the external request falls between reference edges, `pll_rst` falls on `ref_clk` rising edge number `PLL_HOLD`+2.
- R4: `sys_rst` stays high while either the PLL-domain copy of `pll_rst` or the synchronized lock says "not ready". Once lock rises between PLL edges, with the PLL reset already released in that domain, `sys_rst` falls on `pll_clk` rising edge number `SYS_HOLD`+2.
- R5: A drop of lock sets `sys_rst` high on the third `pll_clk` rising edge after the drop. The hold count restarts from zero, so even a one-cycle drop during the hold delays release until `SYS_HOLD`+2 edges after lock returns.
- R6: Each bit of `mod_rst` follows `sys_rst` one `pll_clk` edge later.
- R7: An external reset request during normal operation raises `sys_rst` through the clock crossing alone, with lock still high, within four `pll_clk` edges of `pll_rst` rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| ext_rst_req | input | 1 | Asynchronous external reset request, active-high |
| pll_clk | input | 1 | PLL output clock |
| pll_locked | input | 1 | Asynchronous PLL lock flag, high when locked |
| pll_rst | output | 1 | Reset to the PLL, ref_clk domain, active-high |
| sys_rst | output | 1 | System reset, pll_clk domain, active-high |
| mod_rst | output | NUM_MODS | Per-module registered copies of sys_rst |

## Verification
Every internal fault in this block shows at the ports as a release edge that arrives at the wrong time. A synchronizer that is one flop short or too long moves every assert and release edge by exactly one cycle. A counter loaded with the wrong value, or one that fails to restart, moves the release by many cycles or prevents it. The bench therefore measures edge counts exactly within each domain and checks them against the requirement formulas. A one-cycle lock glitch in the middle of the hold exposes a counter that does not restart, after at most `SYS_HOLD`+2 PLL cycles.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  // Number of flops in every clock-crossing synchronizer.
  localparam int SYNC_STAGES = 2;

  // Width needed to hold the values 0..n.
  function automatic int cnt_w(input int n);
    int w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int   STAGES = rstseq_pkg::SYNC_STAGES,
  parameter logic INIT   = 1'b1
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain = {STAGES{INIT}};

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstseq_pll_hold.sv
module rstseq_pll_hold #(
  parameter int PLL_HOLD = 1000
) (
  input  logic clk,
  input  logic req_s,
  output logic pll_rst
);
  localparam int CW = rstseq_pkg::cnt_w(PLL_HOLD);

  logic [CW-1:0] remain = CW'(PLL_HOLD);
  logic          hold_q = 1'b1;

  always_ff @(posedge clk) begin
    if (req_s) begin
      remain <= CW'(PLL_HOLD);
      hold_q <= 1'b1;
    end else if (remain != '0) begin
      remain <= remain - CW'(1);
      if (remain == CW'(1)) hold_q <= 1'b0;
    end
  end

  assign pll_rst = hold_q;

  // R3: release only after the request has been gone.
  a_r3_release_after_req: assert property (@(posedge clk) disable iff (req_s)
    $fell(hold_q) |-> $past(!req_s));
  // R3: counter never exceeds its load value.
  a_r3_count_bound: assert property (@(posedge clk) disable iff (req_s)
    remain <= CW'(PLL_HOLD));
endmodule

// File: rtl/rstseq_sys_hold.sv
module rstseq_sys_hold #(
  parameter int SYS_HOLD = 4096
) (
  input  logic clk,
  input  logic xrst_s,
  input  logic lock_s,
  output logic sys_rst
);
  localparam int CW = rstseq_pkg::cnt_w(SYS_HOLD);

  logic [CW-1:0] stable = '0;
  logic          held_q = 1'b1;
  logic          not_ready;

  assign not_ready = xrst_s | ~lock_s;

  always_ff @(posedge clk) begin
    if (not_ready) begin
      stable <= '0;
      held_q <= 1'b1;
    end else if (held_q) begin
      if (stable == CW'(SYS_HOLD - 1)) held_q <= 1'b0;
      else stable <= stable + CW'(1);
    end
  end

  assign sys_rst = held_q;

  // R5: lost lock forces the system reset on the next edge.
  a_r5_lock_loss_holds: assert property (@(posedge clk) disable iff (xrst_s)
    !lock_s |=> held_q);
  // R4: release only when lock and released PLL reset were seen.
  a_r4_release_needs_ready: assert property (@(posedge clk) disable iff (xrst_s)
    $fell(held_q) |-> ($past(lock_s) && $past(!xrst_s)));
  // R4: stable count stays below the hold length.
  a_r4_count_bound: assert property (@(posedge clk) disable iff (xrst_s)
    stable < CW'(SYS_HOLD));
endmodule

// File: rtl/rstseq_fanout.sv
module rstseq_fanout #(
  parameter int NUM_MODS = 4
) (
  input  logic                clk,
  input  logic                src_rst,
  output logic [NUM_MODS-1:0] mod_rst
);
  for (genvar i = 0; i < NUM_MODS; i++) begin : g_leg
    logic leg_q = 1'b1;
    always_ff @(posedge clk) begin
      leg_q <= src_rst;
    end
    assign mod_rst[i] = leg_q;
  end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int PLL_HOLD = 1000,
  parameter int SYS_HOLD = 4096,
  parameter int NUM_MODS = 4
) (
  input  logic                ref_clk,
  input  logic                ext_rst_req,
  input  logic                pll_clk,
  input  logic                pll_locked,
  output logic                pll_rst,
  output logic                sys_rst,
  output logic [NUM_MODS-1:0] mod_rst
);
  logic req_s;
  logic xrst_pll;
  logic lock_s;

  // Reference domain: synchronize the request, stretch the PLL reset.
  rstseq_sync #(.STAGES(rstseq_pkg::SYNC_STAGES), .INIT(1'b1)) u_req_sync (
    .clk(ref_clk), .d(ext_rst_req), .q(req_s));

  rstseq_pll_hold #(.PLL_HOLD(PLL_HOLD)) u_pll_hold (
    .clk(ref_clk), .req_s(req_s), .pll_rst(pll_rst));

  // PLL domain: bring over the registered PLL reset and the lock flag.
  rstseq_sync #(.STAGES(rstseq_pkg::SYNC_STAGES), .INIT(1'b1)) u_xrst_sync (
    .clk(pll_clk), .d(pll_rst), .q(xrst_pll));

  rstseq_sync #(.STAGES(rstseq_pkg::SYNC_STAGES), .INIT(1'b0)) u_lock_sync (
    .clk(pll_clk), .d(pll_locked), .q(lock_s));

  rstseq_sys_hold #(.SYS_HOLD(SYS_HOLD)) u_sys_hold (
    .clk(pll_clk), .xrst_s(xrst_pll), .lock_s(lock_s), .sys_rst(sys_rst));

  rstseq_fanout #(.NUM_MODS(NUM_MODS)) u_fanout (
    .clk(pll_clk), .src_rst(sys_rst), .mod_rst(mod_rst));

  // R6: every module reset follows the system reset one edge later.
  a_r6_fan_rise: assert property (@(posedge pll_clk) disable iff (xrst_pll)
    $rose(sys_rst) |=> (&mod_rst));
  a_r6_fan_fall: assert property (@(posedge pll_clk) disable iff (xrst_pll)
    $fell(sys_rst) |=> (mod_rst == '0));
  // R7: while the crossed PLL reset is high, the system reset follows it.
  a_r7_cross_holds: assert property (@(posedge pll_clk) disable iff (1'b0)
    xrst_pll |=> sys_rst);
endmodule

// File: tb/reset_sequencer_test.sv
module reset_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int PLL_PERIOD = 7;
  localparam int PH = 20;
  localparam int SH = 40;
  localparam int NM = 3;
  localparam int LOCK_DLY = 15;

  logic ref_clk = 1'b0;
  logic pll_clk = 1'b0;
  logic ext_rst_req = 1'b1;
  logic pll_locked = 1'b0;
  logic pll_rst, sys_rst;
  logic [NM-1:0] mod_rst;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { string tag; int exp; } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  always #(PLL_PERIOD/2.0) pll_clk = ~pll_clk;

  reset_sequencer #(.PLL_HOLD(PH), .SYS_HOLD(SH), .NUM_MODS(NM)) uut (
    .ref_clk(ref_clk), .ext_rst_req(ext_rst_req), .pll_clk(pll_clk),
    .pll_locked(pll_locked), .pll_rst(pll_rst), .sys_rst(sys_rst),
    .mod_rst(mod_rst));

  // Driver side: queue the expected value.
  task automatic expect_item(input string tag, input int exp);
    sb_q.push_back('{tag, exp});
  endtask

  // Monitor side: pop and compare against what was observed.
  task automatic observe(input int act);
    item_t it;
    checks++;
    if (sb_q.size() == 0) begin
      failures++;
      $display("FAIL scoreboard-empty actual=%0d expected=<none>", act);
    end else begin
      it = sb_q.pop_front();
      if (act != it.exp) begin
        failures++;
        $display("FAIL %s actual=%0d expected=%0d", it.tag, act, it.exp);
      end
    end
  endtask

  task automatic ref_edges_until(input logic lvl, output int n);
    n = 0;
    do begin @(negedge ref_clk); n++; end while (pll_rst !== lvl && n < 5000);
  endtask

  task automatic pll_edges_until(input logic lvl, output int n);
    n = 0;
    do begin @(negedge pll_clk); n++; end while (sys_rst !== lvl && n < 5000);
  endtask

  // Lock model: lock comes LOCK_DLY PLL cycles after PLL reset releases.
  task automatic lock_rise_and_measure(input string tag);
    int n;
    repeat (LOCK_DLY) @(negedge pll_clk);
    pll_locked = 1'b1;
    expect_item(tag, SH + 2);
    pll_edges_until(1'b0, n);
    observe(n);
  endtask

  initial begin
    int n;
    // R1: reset state.
    repeat (10) @(negedge ref_clk);
    expect_item("R1 pll_rst", 1); observe(int'(pll_rst));
    expect_item("R1 sys_rst", 1); observe(int'(sys_rst));
    expect_item("R1 mod_rst", (1 << NM) - 1); observe(int'(mod_rst));

    // R3: PLL reset hold.
    ext_rst_req = 1'b0;
    expect_item("R3 pll hold edges", PH + 2);
    ref_edges_until(1'b0, n); observe(n);
    expect_item("R4 sys_rst held without lock", 1); observe(int'(sys_rst));

    // R4 + R6: release after lock.
    lock_rise_and_measure("R4 sys hold edges");
    expect_item("R6 mod_rst lags sys_rst", (1 << NM) - 1); observe(int'(mod_rst));
    @(negedge pll_clk);
    expect_item("R6 mod_rst released", 0); observe(int'(mod_rst));

    // R5: loss of lock.
    repeat (5) @(negedge pll_clk);
    pll_locked = 1'b0;
    expect_item("R5 lock loss edges", 3);
    pll_edges_until(1'b1, n); observe(n);
    expect_item("R6 mod_rst not yet", 0); observe(int'(mod_rst));
    @(negedge pll_clk);
    expect_item("R6 mod_rst asserted", (1 << NM) - 1); observe(int'(mod_rst));

    // R5: one-cycle glitch during the hold restarts the count.
    repeat (4) @(negedge pll_clk);
    pll_locked = 1'b1;
    repeat (10) @(negedge pll_clk);
    pll_locked = 1'b0;
    @(negedge pll_clk);
    pll_locked = 1'b1;
    expect_item("R5 glitch restarts hold", SH + 2);
    pll_edges_until(1'b0, n); observe(n);

    // R2 + R7: external reset during operation, lock kept high.
    repeat (5) @(negedge ref_clk);
    ext_rst_req = 1'b1;
    expect_item("R2 pll_rst assert edges", 3);
    ref_edges_until(1'b1, n); observe(n);
    pll_edges_until(1'b1, n);
    expect_item("R7 crossing within 4 edges", 1); observe(int'(n <= 4));
    expect_item("R7 lock still high", 1); observe(int'(pll_locked));

    // R4: lock high but request held keeps system in reset.
    repeat (60) @(negedge pll_clk);
    expect_item("R4 held by pll reset", 1); observe(int'(sys_rst));
    expect_item("R1 mod_rst during request", (1 << NM) - 1); observe(int'(mod_rst));

    // Full restart: PLL reset loses lock, then sequence again.
    pll_locked = 1'b0;
    @(negedge ref_clk);
    ext_rst_req = 1'b0;
    expect_item("R3 second pll hold", PH + 2);
    ref_edges_until(1'b0, n); observe(n);
    lock_rise_and_measure("R4 second sys hold");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge ref_clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule